// File: doc/BRIEF.md
# Barrel Shifter With Normalize

This block is a registered barrel shifter for a 16-bit datapath. On each cycle with `opValid` high it performs one operation and loads the result into a 32-bit result register, exposed as a high half and a low half. The operand is placed into either the upper or the lower half of a 32-bit shift field and then shifted by a signed amount. A positive amount shifts left and a negative amount shifts right, with either zero fill or sign fill.

Two further operations support normalization. Exponent detection counts the redundant sign bits of the operand and stores the negated count in an 8-bit exponent register. Normalize then shifts an operand left by that count, so that its first significant bit lands just below the sign bit. An OR-accumulate option merges a new shift result into the existing result register, which lets a wide value be assembled from 16-bit pieces.

Top module: `shiftNormUnit`

## Requirements
- R1: After reset, `resHi`, `resLo` and `expOut` are all zero.
- R2: With `opSel`=0 (logical), a positive `shiftAmt` shifts the field left and a negative `shiftAmt` shifts it right by the magnitude. Vacated bits are filled with zeros, and the result appears on the outputs after the next rising clock edge.
- R3: With `opSel`=1 (arithmetic), a right shift fills the vacated bits with copies of field bit 31. A left shift fills with zeros.
- R4: `placeHi`=1 places `dataIn` in field bits 31:16 with zeros below. `placeHi`=0 places it in bits 15:0; the upper half is zero for the logical operation and a copy of `dataIn[15]` for the arithmetic and normalize operations.
- R5: A shift magnitude of 32 or more gives all zeros for any left shift and for a logical right shift. It gives 32 copies of field bit 31 for an arithmetic right shift (magnitudes up to 128).
- R6: With `opSel`=2 (exponent detect), `expOut` becomes the two's-complement negation of the number of bits below bit 15 that equal `dataIn[15]` before the first differing bit, giving a value from 0 down to -15. The result register is unchanged.
- R7: With `opSel`=3 (normalize), the field built as for the arithmetic operation is shifted by the negation of the current `expOut`, and `shiftAmt` is ignored.
- R8: With `orAcc`=1 on a shift or normalize operation, the new result is the bitwise OR of the shifted field and the previous result register.
- R9: While `opValid` is low, `resHi`, `resLo` and `expOut` hold their values regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Perform the selected operation this cycle |
| opSel | input | 2 | 0 logical shift, 1 arithmetic shift, 2 exponent detect, 3 normalize |
| shiftAmt | input | 8 | Signed shift amount, positive means left |
| placeHi | input | 1 | 1 places the operand in the upper field half, 0 in the lower half |
| orAcc | input | 1 | OR the new result into the existing result |
| dataIn | input | 16 | Operand |
| resHi | output | 16 | Result bits 31:16 |
| resLo | output | 16 | Result bits 15:0 |
| expOut | output | 8 | Exponent register, signed |

## Verification
The bench builds the block with its default parameters: a 16-bit operand and an 8-bit signed amount. At these values every shift magnitude from 0 to 128 can be reached, including the asymmetric -128 case and the whole saturating range at and beyond 32. The exponent register also spans its full reachable range, from 0 to -15. The vector table therefore covers the saturation edges at 31 and 32 on both sides, as well as the sign-fill extremes. Directed sequences then chain exponent detection into normalize and build an accumulated result.

// File: rtl/shiftPkg.sv
package shiftPkg;
  typedef enum logic [1:0] {
    OP_LSH  = 2'd0,
    OP_ASH  = 2'd1,
    OP_EXP  = 2'd2,
    OP_NORM = 2'd3
  } shiftOp_e;

  typedef struct packed {
    logic loadRes;
    logic loadExp;
    logic arith;
    logic useSe;
    logic orAcc;
    logic placeHi;
  } shiftStb_t;
endpackage

// File: rtl/shiftCtrl.sv
module shiftCtrl
  import shiftPkg::*;
(
  input  logic        opValid,
  input  logic [1:0]  opSel,
  input  logic        placeHi,
  input  logic        orAcc,
  output shiftStb_t   stb
);
  shiftOp_e op;

  always_comb begin
    op = shiftOp_e'(opSel);
    stb = '0;
    stb.placeHi = placeHi;
    if (opValid) begin
      unique case (op)
        OP_LSH:  stb.loadRes = 1'b1;
        OP_ASH:  begin stb.loadRes = 1'b1; stb.arith = 1'b1; end
        OP_EXP:  stb.loadExp = 1'b1;
        OP_NORM: begin stb.loadRes = 1'b1; stb.arith = 1'b1; stb.useSe = 1'b1; end
        default: stb = '0;
      endcase
      stb.orAcc = orAcc & stb.loadRes;
    end
  end
endmodule

// File: rtl/expDetect.sv
module expDetect #(
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CNT_W-1:0]  signRun
);
  logic still;

  always_comb begin
    signRun = '0;
    still = 1'b1;
    for (int i = DATA_W - 2; i >= 0; i--) begin
      if (still && (dataIn[i] == dataIn[DATA_W-1])) signRun = signRun + 1'b1;
      else still = 1'b0;
    end
  end
endmodule

// File: rtl/shiftData.sv
module shiftData
  import shiftPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W = 8,
  localparam int RES_W = 2 * DATA_W,
  localparam int SH_W = $clog2(RES_W),
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  shiftStb_t               stb,
  input  logic [DATA_W-1:0]       dataIn,
  input  logic signed [AMT_W-1:0] shiftAmt,
  output logic [RES_W-1:0]        resOut,
  output logic signed [AMT_W-1:0] seOut
);
  logic [RES_W-1:0]        resReg;
  logic signed [AMT_W-1:0] seReg;
  logic signed [RES_W-1:0] field;
  logic signed [AMT_W-1:0] amtEff;
  logic [AMT_W:0]          mag;
  logic                    rightDir, tooFar, fillBit;
  logic [RES_W-1:0]        shifted, nextRes;
  logic [CNT_W-1:0]        signRun;

  expDetect #(.DATA_W(DATA_W)) uExp (.dataIn(dataIn), .signRun(signRun));

  always_comb begin
    if (stb.placeHi)    field = {dataIn, {DATA_W{1'b0}}};
    else if (stb.arith) field = {{DATA_W{dataIn[DATA_W-1]}}, dataIn};
    else                field = {{DATA_W{1'b0}}, dataIn};

    amtEff   = stb.useSe ? -seReg : shiftAmt;
    rightDir = amtEff[AMT_W-1];
    mag      = rightDir ? -{amtEff[AMT_W-1], amtEff} : {1'b0, amtEff};
    tooFar   = mag >= (AMT_W+1)'(RES_W);
    fillBit  = stb.arith & field[RES_W-1];

    if (!rightDir)   shifted = tooFar ? '0 : field << mag[SH_W-1:0];
    else if (tooFar) shifted = {RES_W{fillBit}};
    else if (stb.arith) shifted = field >>> mag[SH_W-1:0];
    else             shifted = field >> mag[SH_W-1:0];

    nextRes = stb.orAcc ? (shifted | resReg) : shifted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resReg <= '0;
      seReg  <= '0;
    end else begin
      if (stb.loadRes) resReg <= nextRes;
      if (stb.loadExp) seReg  <= AMT_W'(0) - AMT_W'(signRun);
    end
  end

  assign resOut = resReg;
  assign seOut  = seReg;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadRes && !stb.loadExp) |=> ($stable(resReg) && $stable(seReg))); // R9
  AST_EXP_KEEPS_RES: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadExp |=> $stable(resReg)); // R6
  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (seReg <= 0) && (seReg >= -AMT_W'(DATA_W - 1))); // R6
  AST_OR_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadRes && stb.orAcc) |=> ((resReg & $past(resReg)) == $past(resReg))); // R8
  AST_LOGIC_FAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadRes && !stb.orAcc && !stb.arith &&
     ((shiftAmt >= AMT_W'(RES_W)) || (shiftAmt <= -AMT_W'(RES_W)))) |=> (resReg == '0)); // R5
endmodule

// File: rtl/shiftNormUnit.sv
module shiftNormUnit
  import shiftPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int AMT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opSel,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic              placeHi,
  input  logic              orAcc,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] resHi,
  output logic [DATA_W-1:0] resLo,
  output logic [AMT_W-1:0]  expOut
);
  shiftStb_t               stb;
  logic [2*DATA_W-1:0]     res;
  logic signed [AMT_W-1:0] se;

  shiftCtrl uCtrl (
    .opValid(opValid), .opSel(opSel), .placeHi(placeHi), .orAcc(orAcc), .stb(stb)
  );

  shiftData #(.DATA_W(DATA_W), .AMT_W(AMT_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn),
    .shiftAmt($signed(shiftAmt)), .resOut(res), .seOut(se)
  );

  assign resHi  = res[2*DATA_W-1:DATA_W];
  assign resLo  = res[DATA_W-1:0];
  assign expOut = se;
endmodule

// File: tb/sim_shiftNormUnit.sv
module sim_shiftNormUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [7:0]  shiftAmt = 8'd0;
  logic        placeHi = 1'b0;
  logic        orAcc = 1'b0;
  logic [15:0] dataIn = 16'd0;
  logic [15:0] resHi, resLo;
  logic [7:0]  expOut;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  shiftNormUnit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .shiftAmt(shiftAmt),
    .placeHi(placeHi), .orAcc(orAcc), .dataIn(dataIn),
    .resHi(resHi), .resLo(resLo), .expOut(expOut)
  );

  // {op, amt, placeHi, dataIn, expected result}
  localparam logic [58:0] VEC [15] = '{
    {2'd0, 8'h04, 1'b0, 16'h8001, 32'h0008_0010},  // R2 left
    {2'd0, 8'hFC, 1'b1, 16'h8001, 32'h0800_1000},  // R2 right, R4 hi
    {2'd1, 8'hFC, 1'b1, 16'h8001, 32'hF800_1000},  // R3
    {2'd1, 8'hFC, 1'b0, 16'h8001, 32'hFFFF_F800},  // R3 R4 lo sign-ext
    {2'd0, 8'hFC, 1'b0, 16'h8001, 32'h0000_0800},  // R4 lo zero-ext
    {2'd1, 8'h08, 1'b0, 16'h00F0, 32'h0000_F000},  // R3 left
    {2'd0, 8'h20, 1'b0, 16'hFFFF, 32'h0000_0000},  // R5
    {2'd0, 8'hE0, 1'b1, 16'hFFFF, 32'h0000_0000},  // R5
    {2'd1, 8'hD8, 1'b1, 16'h8000, 32'hFFFF_FFFF},  // R5
    {2'd1, 8'h80, 1'b0, 16'h1234, 32'h0000_0000},  // R5
    {2'd0, 8'h1F, 1'b0, 16'h0001, 32'h8000_0000},  // R2 edge 31
    {2'd1, 8'hE1, 1'b1, 16'h8000, 32'hFFFF_FFFF},  // R3 edge -31
    {2'd0, 8'h10, 1'b0, 16'hABCD, 32'hABCD_0000},  // R2
    {2'd0, 8'h00, 1'b1, 16'h1234, 32'h1234_0000},  // R4
    {2'd1, 8'h7F, 1'b0, 16'h7FFF, 32'h0000_0000}   // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [1:0] op, input logic [7:0] amt, input logic hi,
                      input logic acc, input logic [15:0] din);
    @(negedge clk);
    opSel = op; shiftAmt = amt; placeHi = hi; orAcc = acc; dataIn = din; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 result", {resHi, resLo}, 32'h0);
    chk("R1 exp", {24'h0, expOut}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < 15; i++) begin
      doOp(VEC[i][58:57], VEC[i][56:49], VEC[i][48], 1'b0, VEC[i][47:32]);
      chk($sformatf("R2-R5 vector %0d", i), {resHi, resLo}, VEC[i][31:0]);
    end

    // R6 exponent detect keeps result
    doOp(2'd0, 8'h00, 1'b1, 1'b0, 16'h5A5A);
    doOp(2'd2, 8'h05, 1'b0, 1'b0, 16'h0001);
    chk("R6 exp 0001", {24'h0, expOut}, 32'h0000_00F2);
    chk("R6 result kept", {resHi, resLo}, 32'h5A5A_0000);
    // R7 normalize with SE=-14, shiftAmt ignored
    doOp(2'd3, 8'hF0, 1'b1, 1'b0, 16'h0001);
    chk("R7 norm 0001", {resHi, resLo}, 32'h4000_0000);
    doOp(2'd2, 8'h00, 1'b0, 1'b0, 16'hFFFF);
    chk("R6 exp FFFF", {24'h0, expOut}, 32'h0000_00F1);
    doOp(2'd2, 8'h00, 1'b0, 1'b0, 16'h0000);
    chk("R6 exp 0000", {24'h0, expOut}, 32'h0000_00F1);
    doOp(2'd2, 8'h00, 1'b0, 1'b0, 16'h4000);
    chk("R6 exp 4000", {24'h0, expOut}, 32'h0);
    doOp(2'd2, 8'h00, 1'b0, 1'b0, 16'hC000);
    chk("R6 exp C000", {24'h0, expOut}, 32'h0000_00FF);
    doOp(2'd3, 8'h00, 1'b0, 1'b0, 16'hC000);
    chk("R7 norm lo C000", {resHi, resLo}, 32'hFFFF_8000);
    doOp(2'd3, 8'h00, 1'b1, 1'b0, 16'hC000);
    chk("R7 norm hi C000", {resHi, resLo}, 32'h8000_0000);

    // R8 OR-accumulate
    doOp(2'd0, 8'h00, 1'b0, 1'b0, 16'h00FF);
    doOp(2'd0, 8'h08, 1'b0, 1'b1, 16'h0F0F);
    chk("R8 or step1", {resHi, resLo}, 32'h000F_0FFF);
    doOp(2'd1, 8'hFC, 1'b1, 1'b1, 16'h8000);
    chk("R8 or step2", {resHi, resLo}, 32'hF80F_0FFF);

    // R9 idle hold
    @(negedge clk);
    opSel = 2'd2; shiftAmt = 8'h03; placeHi = 1'b1; orAcc = 1'b0; dataIn = 16'h0001;
    repeat (4) @(negedge clk);
    chk("R9 result held", {resHi, resLo}, 32'hF80F_0FFF);
    chk("R9 exp held", {24'h0, expOut}, 32'h0000_00FF);

    // R1 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 reset result", {resHi, resLo}, 32'h0);
    chk("R1 reset exp", {24'h0, expOut}, 32'h0);
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule